// File: doc/BRIEF.md
# PC-Card Strobe Timing Sequencer

This block connects a CPU-side request port to an external PC-card style socket that is mapped into one 64 MB window of the address space. A request that hits the window is steered by one offset bit. The lower half becomes a memory-card cycle, driven with output-enable and write-enable strobes. The upper half becomes an I/O-card cycle, driven with I/O-read and I/O-write strobes. Card enables select the byte lanes, and the card offset and write data are held steady for the whole access.

The sequencer runs on a clock at twice the bus rate, so every count it makes is one half bus cycle. The access has three programmable intervals:
- a setup interval, from card-enable assertion to strobe assertion;
- a strobe interval, stretched by a wait-state count and, after that, by a card ready input;
- a hold interval, from strobe release to card-enable release.

When the access ends, a one-cycle completion pulse is raised. For reads, the lane-aligned read data is presented at the same time.

Top module: `pcard_strobe_gen`

## Requirements
- R1: A request starts an access only when `req_addr[28:26]` equals 3'b110. Bits 31..29 do not take part in the decode. A request outside the window leaves `busy` low and every strobe and card enable high.
- R2: When `req_addr[25]` is 0, the access is a memory access: a read drives `card_oe_n` low and a write drives `card_we_n` low. When it is 1, the access is an I/O access: a read drives `card_iord_n` low and a write drives `card_iowr_n` low. At most one strobe is low at any time.
- R3: The card enables go low `2*cfg_setup+1` clock cycles before the strobe falls, and no strobe is low unless a card enable is low.
- R4: The strobe stays low for `2*(1+W)` clock cycles. W is the wait count taken from `cfg_wait`: codes 0 to 4 give W equal to the code, and codes 5, 6 and 7 give W = 6, 8 and 10.
- R5: The card enables stay low `2*cfg_hold+1` clock cycles after the strobe rises.
- R6: `cfg_size` 2'b01 selects a byte access, and every other code selects a word access. A word access drives both `card_ce1_n` (low lane, bits 7:0) and `card_ce2_n` (high lane, bits 15:8) low. A byte access drives only `card_ce1_n` low when `req_addr[0]` is 0, and only `card_ce2_n` low when it is 1.
- R7: `card_ready` is sampled on the last cycle of the strobe interval. While it is low there, the strobe is held low one more cycle at a time, until a cycle in which it is high.
- R8: A read captures `card_rdata` as the strobe ends. `done` is high for exactly one cycle, once the card enables have risen, and `rd_data` is valid in that cycle. A word read returns all 16 bits. A byte read returns the selected lane in bits 7:0, with bits 15:8 set to zero.
- R9: During an access, `card_addr` carries `req_addr[24:0]` and stays stable. For a write, `card_wdata` carries `req_wdata` for a word access, and `req_wdata[7:0]` on both lanes for a byte access.
- R10: After reset, all strobes and card enables are high, and `busy` and `done` are low.
- R11: A request that arrives while `busy` is high is ignored. It produces no second access and does not change `card_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| cfg_size | input | 2 | Bus width code (01 byte, else word) |
| cfg_setup | input | 2 | Setup code, (2n+1) half cycles |
| cfg_wait | input | 3 | Wait-state code |
| cfg_hold | input | 2 | Hold code, (2n+1) half cycles |
| card_ready | input | 1 | Card ready, high = finish strobe |
| card_rdata | input | 16 | Data from the card |
| card_addr | output | 25 | Card offset |
| card_wdata | output | 16 | Data to the card |
| card_ce1_n | output | 1 | Low-lane card enable, active low |
| card_ce2_n | output | 1 | High-lane card enable, active low |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_we_n | output | 1 | Memory write strobe, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Lane-aligned read data |

## Verification
The hardest situation to reach is a strobe extended by a slow card: `card_ready` has to be low on exactly the cycle in which the wait count runs out. It then has to rise at a known later cycle, so that the expected strobe width is exact. The stimulus holds ready low before issuing the request. It counts the half cycles in which a strobe is low, and raises ready only after the nominal width plus a chosen extra count. A second hard case is a request that collides with an access already in flight. This is produced by pulsing `req_valid` with a different window address in the middle of an access, then confirming that only one completion occurs and that the card offset did not move.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 25;
    localparam int DATA_W = 16;
    localparam int MAX_W  = 10;
    localparam int CNT_W  = $clog2(2 * (MAX_W + 1) + 1);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic              io_space;
        logic              write;
        logic              lane_lo;
        logic              lane_hi;
        logic [OFS_W-1:0]  addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // wait code -> wait cycles: 0..4 linear, then 6, 8, 10
    function automatic logic [3:0] wait_cycles(input logic [2:0] code);
        if (code <= 3'd4) return {1'b0, code};
        else              return {code - 3'd2, 1'b0};
    endfunction

    // last counter index of a (2n+1)-half-cycle interval
    function automatic logic [CNT_W-1:0] edge_last(input logic [1:0] code);
        return CNT_W'({code, 1'b0});
    endfunction

    // last counter index of a 2*(1+W)-half-cycle strobe
    function automatic logic [CNT_W-1:0] strobe_last(input logic [2:0] code);
        return CNT_W'({wait_cycles(code), 1'b1});
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
#(
    parameter logic [2:0] WIN_CODE = 3'b110
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              hit,
    output logic              io_space,
    output logic              lane_lo,
    output logic              lane_hi
);
    logic is_byte;
    logic addr_unused;

    assign addr_unused = ^{addr[31:29], addr[24:1]};
    assign hit         = (addr[28:26] == WIN_CODE);
    assign io_space    = addr[25];
    assign is_byte     = (size == 2'b01);
    assign lane_lo     = !is_byte || !addr[0];
    assign lane_hi     = !is_byte ||  addr[0];

endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] cfg_setup,
    input  logic [2:0] cfg_wait,
    input  logic [1:0] cfg_hold,
    input  logic       ready,
    output phase_t     phase,
    output logic       capture,
    output logic       done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       wait_q;
    logic [1:0]       hold_q;

    assign phase   = ph;
    assign capture = (ph == PH_STROBE) && (cnt == '0) && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            wait_q <= '0;
            hold_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    ph     <= PH_SETUP;
                    cnt    <= edge_last(cfg_setup);
                    wait_q <= cfg_wait;
                    hold_q <= cfg_hold;
                end
                PH_SETUP: if (cnt == '0) begin
                    ph  <= PH_STROBE;
                    cnt <= strobe_last(wait_q);
                end else cnt <= cnt - ONE;
                PH_STROBE: if (cnt != '0) cnt <= cnt - ONE;
                else if (ready) begin
                    ph  <= PH_HOLD;
                    cnt <= edge_last(hold_q);
                end
                default: if (cnt == '0) begin
                    ph   <= PH_IDLE;
                    done <= 1'b1;
                end else cnt <= cnt - ONE;
            endcase
        end
    end

    // R3: strobe phase is only entered from setup
    a_r3_setup_first: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STROBE && $past(ph) != PH_STROBE) |-> $past(ph) == PH_SETUP);
    // R5: return to idle only through hold, with the completion pulse
    a_r5_hold_last: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && $past(ph) != PH_IDLE) |-> ($past(ph) == PH_HOLD && done));
    // R7: strobe never ends while ready is low at the last count
    a_r7_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STROBE && cnt == '0 && !ready) |=> ph == PH_STROBE);

endmodule

// File: rtl/pcard_strobe_gen.sv
module pcard_strobe_gen
    import pcs_pkg::*;
#(
    parameter logic [2:0] WIN_CODE = 3'b110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        cfg_size,
    input  logic [1:0]        cfg_setup,
    input  logic [2:0]        cfg_wait,
    input  logic [1:0]        cfg_hold,
    input  logic              card_ready,
    input  logic [15:0]       card_rdata,
    output logic [24:0]       card_addr,
    output logic [15:0]       card_wdata,
    output logic              card_ce1_n,
    output logic              card_ce2_n,
    output logic              card_oe_n,
    output logic              card_we_n,
    output logic              card_iord_n,
    output logic              card_iowr_n,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data
);
    logic   hit, dec_io, dec_lo, dec_hi;
    logic   start, capture, active, strobing;
    phase_t phase;
    xfer_t  xq;

    pcs_decode #(.WIN_CODE(WIN_CODE)) u_dec (
        .addr     (req_addr),
        .size     (cfg_size),
        .hit      (hit),
        .io_space (dec_io),
        .lane_lo  (dec_lo),
        .lane_hi  (dec_hi)
    );

    assign start = req_valid && hit && (phase == PH_IDLE);

    pcs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_setup (cfg_setup),
        .cfg_wait  (cfg_wait),
        .cfg_hold  (cfg_hold),
        .ready     (card_ready),
        .phase     (phase),
        .capture   (capture),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xq      <= '0;
            rd_data <= '0;
        end else begin
            if (start) begin
                xq.io_space <= dec_io;
                xq.write    <= req_write;
                xq.lane_lo  <= dec_lo;
                xq.lane_hi  <= dec_hi;
                xq.addr     <= req_addr[OFS_W-1:0];
                xq.wdata    <= (dec_lo && dec_hi) ? req_wdata
                                                  : {req_wdata[7:0], req_wdata[7:0]};
            end
            if (capture && !xq.write) begin
                if (xq.lane_lo && xq.lane_hi) rd_data <= card_rdata;
                else if (xq.lane_hi)          rd_data <= {8'h00, card_rdata[15:8]};
                else                          rd_data <= {8'h00, card_rdata[7:0]};
            end
        end
    end

    assign active      = (phase != PH_IDLE);
    assign strobing    = (phase == PH_STROBE);
    assign busy        = active;
    assign card_addr   = xq.addr;
    assign card_wdata  = xq.wdata;
    assign card_ce1_n  = !(active && xq.lane_lo);
    assign card_ce2_n  = !(active && xq.lane_hi);
    assign card_oe_n   = !(strobing && !xq.io_space && !xq.write);
    assign card_we_n   = !(strobing && !xq.io_space &&  xq.write);
    assign card_iord_n = !(strobing &&  xq.io_space && !xq.write);
    assign card_iowr_n = !(strobing &&  xq.io_space &&  xq.write);

    // R2: never two strobes at once
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n}) <= 1);
    // R3: a strobe is always framed by a card enable
    a_r3_strobe_in_ce: assert property (@(posedge clk) disable iff (rst)
        !(card_oe_n && card_we_n && card_iord_n && card_iowr_n) |-> !(card_ce1_n && card_ce2_n));
    // R1: an out-of-window request never starts an access
    a_r1_window_only: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_addr[28:26] != WIN_CODE) |=> !busy);
    // R9 / R11: offset stable through an access
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(card_addr));
    // R8: completion is a single-cycle pulse outside the access
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

endmodule

// File: tb/pcard_strobe_gen_tb_top.sv
module pcard_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  cfg_size = 2'b10;
    logic [1:0]  cfg_setup = '0;
    logic [2:0]  cfg_wait = '0;
    logic [1:0]  cfg_hold = '0;
    logic        card_ready = 1'b1;
    logic [15:0] card_rdata = '0;
    logic [24:0] card_addr;
    logic [15:0] card_wdata, rd_data;
    logic        card_ce1_n, card_ce2_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n;
    logic        busy, done;

    always #2 clk = !clk;  // 250 MHz

    pcard_strobe_gen dut_i (.*);

    typedef struct {
        int          su, st, ho;
        logic [3:0]  kind;
        logic [1:0]  ce;
        logic [24:0] addr;
        logic [15:0] wdata, rdata;
        logic        rd;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int wait_of(input logic [2:0] c);
        return (c <= 4) ? int'(c) : 2 * int'(c) - 4;
    endfunction

    // monitor / scoreboard
    int m_su = 0, m_st = 0, m_ho = 0;
    logic [3:0] m_kind = '0;
    logic [1:0] m_ce = '0;
    logic [24:0] m_addr = '0;
    logic [15:0] m_wd = '0;

    initial forever begin
        @(negedge clk);
        if (!rst) begin
            logic [3:0] sl;
            logic [1:0] cl;
            sl = {!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n};
            cl = {!card_ce2_n, !card_ce1_n};
            m_ce |= cl;
            if (sl != 0) begin
                m_st++;
                m_kind |= sl;
                m_addr = card_addr;
                m_wd = card_wdata;
            end else if (cl != 0) begin
                if (m_st == 0) m_su++;
                else m_ho++;
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R11 extra completion", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(m_su == e.su, "R3 setup", m_su, e.su);
                    chk(m_st == e.st, "R4/R7 strobe width", m_st, e.st);
                    chk(m_ho == e.ho, "R5 hold", m_ho, e.ho);
                    chk(m_kind == e.kind, "R2 strobe kind", m_kind, e.kind);
                    chk(m_ce == e.ce, "R6 lanes", m_ce, e.ce);
                    chk(m_addr == e.addr, "R9 card_addr", m_addr, e.addr);
                    if (e.rd) chk(rd_data == e.rdata, "R8 rd_data", rd_data, e.rdata);
                    else      chk(m_wd == e.wdata, "R9 card_wdata", m_wd, e.wdata);
                end
                m_su = 0; m_st = 0; m_ho = 0; m_kind = '0; m_ce = '0;
            end
        end
    end

    task automatic xfer(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                        input logic [15:0] wd, input logic [1:0] su, input logic [2:0] wt,
                        input logic [1:0] ho, input int extra, input bit overlap);
        exp_t e;
        int base, k, cyc;
        logic [15:0] pat;
        bit is_b;
        pat  = 16'hA5C3 ^ a[15:0];
        is_b = (sz == 2'b01);
        base = 2 * (1 + wait_of(wt));
        e.su = 2 * int'(su) + 1;
        e.st = base + extra;
        e.ho = 2 * int'(ho) + 1;
        e.kind = a[25] ? (wr ? 4'b0001 : 4'b0010) : (wr ? 4'b0100 : 4'b1000);
        e.ce = !is_b ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
        e.addr = a[24:0];
        e.wdata = is_b ? {wd[7:0], wd[7:0]} : wd;
        e.rdata = !is_b ? pat : (a[0] ? {8'h00, pat[15:8]} : {8'h00, pat[7:0]});
        e.rd = !wr;
        exp_q.push_back(e);
        @(negedge clk);
        card_rdata = pat;
        card_ready = (extra == 0);
        cfg_size = sz; cfg_setup = su; cfg_wait = wt; cfg_hold = ho;
        req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0; cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (overlap && cyc == 3) begin
                req_valid = 1'b1; req_addr = 32'h1800_1000; req_write = !wr;
            end
            if (overlap && cyc == 4) req_valid = 1'b0;
            if (!(card_oe_n && card_we_n && card_iord_n && card_iowr_n)) begin
                k++;
                if (extra > 0 && k == base + extra) card_ready = 1'b1;
            end
            if (done) break;
        end
        card_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk({card_ce1_n, card_ce2_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n} == 6'h3f,
            "R10 strobes idle", {card_ce1_n, card_ce2_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n}, 6'h3f);
        chk(!busy && !done, "R10 busy/done", {busy, done}, 0);

        xfer(32'h1800_0100, 0, 2'b10, 16'h0000, 2'd0, 3'd0, 2'd0, 0, 0);  // R2 R6 R8 word mem read
        xfer(32'h1800_0202, 1, 2'b10, 16'hBEEF, 2'd3, 3'd7, 2'd2, 0, 0);  // R9 word mem write
        xfer(32'h1800_0013, 0, 2'b01, 16'h0000, 2'd1, 3'd5, 2'd3, 0, 0);  // R6 odd byte read
        xfer(32'h1A00_0020, 1, 2'b01, 16'h3C96, 2'd2, 3'd6, 2'd1, 0, 0);  // R2 io byte write
        xfer(32'hFA00_0044, 0, 2'b11, 16'h0000, 2'd0, 3'd4, 2'd0, 0, 0);  // R1 shadow io read
        xfer(32'h1800_0031, 0, 2'b10, 16'h0000, 2'd1, 3'd2, 2'd1, 3, 0);  // R7 ready extension
        xfer(32'h1A00_0500, 1, 2'b10, 16'h1234, 2'd0, 3'd1, 2'd0, 0, 1);  // R11 overlap

        // R11: no second access after overlap
        repeat (3) begin
            @(negedge clk);
            chk(!busy, "R11 no extra access", busy, 0);
        end

        // R1: out-of-window request ignored
        @(negedge clk);
        req_addr = 32'h1C00_0000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!busy && card_ce1_n && card_ce2_n && card_oe_n && card_iord_n,
                "R1 outside window", busy, 0);
        end
        chk(exp_q.size() == 0, "R8 all completions seen", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule